// File: doc/BRIEF.md
# Saturating Width Resize Unit

This block converts a data word from one width to another for signed (two's-complement) or unsigned numbers. If the output is at least as wide as the input, the value is extended and kept exactly. If the output is narrower, the block either wraps the value by keeping its low bits or saturates it to the nearest end of the output range, as a parameter selects. Signed saturation can be made symmetric. In that case the most negative output code is never produced, so negating the result cannot overflow.

An overflow flag runs alongside the data and moves through the same register stages. It tells the consumer that the input did not fit the output range, whether or not saturation was applied. Two parameters set the number of register stages in front of and behind the conversion logic. A count of zero makes that side purely combinational. All options are fixed at elaboration time; there are no run-time modes.

The block has no control state machine. It has one state element: a pipeline that is either empty after reset or carrying data. The reset transition loads zeros into every stage. The run transition shifts one word per clock.

Top module: `sat_resize`

## Requirements
- R1: Latency from `din` to `dout`/`ovf` is `IN_STAGES + OUT_STAGES` clocks (1 in the default setup of 0 input stages and 1 output stage). A stage count of 0 adds no delay.
- R2: While `rst_n` is low, every register stage holds zero, so `dout` and `ovf` read 0 when at least one stage exists.
- R3: When `OUT_W >= IN_W`, a signed input is sign-extended, an unsigned input is zero-extended, and `ovf` is 0.
- R4: When `OUT_W < IN_W` and `SATURATE` is 0, `dout` equals the low `OUT_W` bits of the input for both representations.
- R5: For unsigned narrowing with `SATURATE`=1, an input above 2^OUT_W−1 gives `dout` = 2^OUT_W−1 (all ones). In-range inputs pass unchanged.
- R6: For signed narrowing with `SATURATE`=1 and `SYMMETRIC`=0, an input below −2^(OUT_W−1) gives that minimum code. An input above 2^(OUT_W−1)−1 gives that maximum code.
- R7: For signed narrowing with `SATURATE`=1 and `SYMMETRIC`=1, out-of-range inputs give −(2^(OUT_W−1)−1) or +(2^(OUT_W−1)−1). The code −2^(OUT_W−1) (sign bit 1, other bits 0) never appears on `dout`, not even for an input exactly equal to it.
- R8: `ovf` is 1 exactly when the input value cannot be represented in `OUT_W` bits of the chosen representation, independent of `SATURATE` and `SYMMETRIC`. It is aligned with the data it belongs to. An input equal to −2^(OUT_W−1) is representable, so it gives `ovf`=0 even when symmetric saturation changes its code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all register stages |
| rst_n | input | 1 | Active-low asynchronous reset that clears all stages |
| din | input | IN_W | Input word, signed or unsigned per `REPR` |
| dout | output | OUT_W | Resized output word |
| ovf | output | 1 | Input was out of the output range |

## Verification
A data bit dropped in a pipeline stage, or a stage count off by one, shows up as a mismatch on `dout` one latency after the affected input. Only the two-stage instance tells latency errors apart from value errors. A wrong range test, for example comparing one bit too few of the dropped high part, shows up as a wrong `ovf` and a wrong saturation code in the same output cycle. The input range is only 32 codes, so every one is driven through every configuration before the random phase. The symmetric minimum code and both range edges are therefore hit deterministically.

// File: rtl/sat_resize_pkg.sv
package sat_resize_pkg;
    typedef enum logic {
        REPR_SIGNED   = 1'b0,
        REPR_UNSIGNED = 1'b1
    } repr_e;
endpackage

// File: rtl/rsz_delay.sv
module rsz_delay #(
    parameter int W     = 4,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (DEPTH == 0) begin : g_bypass
            logic unused_ctl;
            assign unused_ctl = clk ^ rst_n;
            assign q = d;
        end else begin : g_regs
            logic [W-1:0] stage [DEPTH];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
                end else begin
                    stage[0] <= d;
                    for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
                end
            end
            assign q = stage[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/rsz_core.sv
module rsz_core
    import sat_resize_pkg::*;
#(
    parameter repr_e REPR      = REPR_SIGNED,
    parameter int    IN_W      = 5,
    parameter int    OUT_W     = 3,
    parameter bit    SATURATE  = 1'b1,
    parameter bit    SYMMETRIC = 1'b1
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout,
    output logic             ovf
);
    localparam logic [OUT_W-1:0] SMIN = OUT_W'(1) << (OUT_W - 1);
    localparam logic [OUT_W-1:0] SMAX = ~SMIN;
    localparam logic [OUT_W-1:0] UMAX = '1;

    generate
        if (OUT_W > IN_W) begin : g_widen
            if (REPR == REPR_SIGNED) begin : g_sext
                assign dout = {{(OUT_W-IN_W){din[IN_W-1]}}, din};
            end else begin : g_zext
                assign dout = {{(OUT_W-IN_W){1'b0}}, din};
            end
            assign ovf = 1'b0;
        end else if (OUT_W == IN_W) begin : g_same
            assign dout = din;
            assign ovf  = 1'b0;
        end else begin : g_narrow
            logic [OUT_W-1:0] low_bits;
            logic [OUT_W-1:0] limit;
            logic [OUT_W-1:0] pre;
            logic             fits;
            assign low_bits = din[OUT_W-1:0];
            if (REPR == REPR_SIGNED) begin : g_srange
                assign fits  = (din[IN_W-1:OUT_W-1] == '0) || (din[IN_W-1:OUT_W-1] == '1);
                assign limit = din[IN_W-1] ? SMIN : SMAX;
            end else begin : g_urange
                assign fits  = (din[IN_W-1:OUT_W] == '0);
                assign limit = UMAX;
            end
            always_comb begin
                pre = (SATURATE && !fits) ? limit : low_bits;
                if (REPR == REPR_SIGNED && SATURATE && SYMMETRIC && pre == SMIN)
                    dout = SMIN + OUT_W'(1);
                else
                    dout = pre;
            end
            assign ovf = !fits;
        end
    endgenerate
endmodule

// File: rtl/sat_resize.sv
module sat_resize
    import sat_resize_pkg::*;
#(
    parameter repr_e REPR       = REPR_SIGNED,
    parameter int    IN_W       = 5,
    parameter int    OUT_W      = 3,
    parameter bit    SATURATE   = 1'b1,
    parameter bit    SYMMETRIC  = 1'b1,
    parameter int    IN_STAGES  = 0,
    parameter int    OUT_STAGES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout,
    output logic             ovf
);
    localparam bit NARROW = (OUT_W < IN_W);
    localparam logic [OUT_W-1:0] SMIN = OUT_W'(1) << (OUT_W - 1);
    localparam logic [OUT_W-1:0] SMAX = ~SMIN;

    logic [IN_W-1:0]  din_q;
    logic [OUT_W-1:0] core_dat;
    logic             core_ovf;

    rsz_delay #(.W(IN_W), .DEPTH(IN_STAGES)) u_in_pipe (
        .clk(clk), .rst_n(rst_n), .d(din), .q(din_q)
    );

    rsz_core #(
        .REPR(REPR), .IN_W(IN_W), .OUT_W(OUT_W),
        .SATURATE(SATURATE), .SYMMETRIC(SYMMETRIC)
    ) u_core (
        .din(din_q), .dout(core_dat), .ovf(core_ovf)
    );

    rsz_delay #(.W(OUT_W + 1), .DEPTH(OUT_STAGES)) u_out_pipe (
        .clk(clk), .rst_n(rst_n), .d({core_ovf, core_dat}), .q({ovf, dout})
    );

    generate
        if (!NARROW) begin : g_chk_widen
            assert_widen_no_ovf_R3: assert property (@(posedge clk) disable iff (!rst_n)
                !ovf);
        end
        if (NARROW && SATURATE && REPR == REPR_UNSIGNED) begin : g_chk_uclip
            assert_uclip_all_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
                ovf |-> (dout == '1));
        end
        if (NARROW && SATURATE && REPR == REPR_SIGNED && !SYMMETRIC) begin : g_chk_sclip
            assert_sclip_limits_R6: assert property (@(posedge clk) disable iff (!rst_n)
                ovf |-> (dout[OUT_W-1] ? (dout == SMIN) : (dout == SMAX)));
        end
        if (NARROW && SATURATE && REPR == REPR_SIGNED && SYMMETRIC) begin : g_chk_sym
            assert_sym_no_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
                dout != SMIN);
            assert_sym_limits_R7: assert property (@(posedge clk) disable iff (!rst_n)
                ovf |-> (dout == SMAX || dout == SMIN + OUT_W'(1)));
        end
    endgenerate
endmodule

// File: tb/sat_resize_bench.sv
module sat_resize_bench;
    import sat_resize_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] din = '0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [2:0] a_d, b_d, c_d, d_d, e_d, h_d;
    logic [6:0] f_d, g_d;
    logic a_o, b_o, c_o, d_o, e_o, f_o, g_o, h_o;

    sat_resize u_sat_resize (.clk(clk), .rst_n(rst_n), .din(din), .dout(a_d), .ovf(a_o));
    sat_resize #(.SYMMETRIC(1'b0)) u_sasym (.clk(clk), .rst_n(rst_n), .din(din), .dout(b_d), .ovf(b_o));
    sat_resize #(.SATURATE(1'b0)) u_swrap (.clk(clk), .rst_n(rst_n), .din(din), .dout(c_d), .ovf(c_o));
    sat_resize #(.REPR(REPR_UNSIGNED)) u_uclip (.clk(clk), .rst_n(rst_n), .din(din), .dout(d_d), .ovf(d_o));
    sat_resize #(.REPR(REPR_UNSIGNED), .SATURATE(1'b0)) u_uwrap (.clk(clk), .rst_n(rst_n), .din(din), .dout(e_d), .ovf(e_o));
    sat_resize #(.OUT_W(7)) u_swide (.clk(clk), .rst_n(rst_n), .din(din), .dout(f_d), .ovf(f_o));
    sat_resize #(.REPR(REPR_UNSIGNED), .OUT_W(7)) u_uwide (.clk(clk), .rst_n(rst_n), .din(din), .dout(g_d), .ovf(g_o));
    sat_resize #(.IN_STAGES(1), .OUT_STAGES(1)) u_deep (.clk(clk), .rst_n(rst_n), .din(din), .dout(h_d), .ovf(h_o));

    // Reference model: returns {ovf, data[7:0]}
    function automatic logic [8:0] model(bit sgn, bit sat, bit sym, int ow, logic [4:0] x);
        int v, lo, hi, r, mask;
        bit of;
        mask = (1 << ow) - 1;
        v = (sgn && x[4]) ? int'(x) - 32 : int'(x);
        if (ow >= 5) return {1'b0, 8'(v & mask)};
        if (sgn) begin lo = -(1 << (ow - 1)); hi = (1 << (ow - 1)) - 1; end
        else begin lo = 0; hi = mask; end
        of = (v < lo) || (v > hi);
        r = v;
        if (sat) begin
            if (r < lo) r = lo;
            if (r > hi) r = hi;
            if (sgn && sym && r == lo) r = lo + 1;
        end
        return {of, 8'(r & mask)};
    endfunction

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    task automatic chk_pair(input string req, input string what, input int gd, input bit go,
                            input logic [8:0] e);
        chk(req, {what, " data"}, gd, int'(e[7:0]));
        chk("R8", {what, " ovf"}, int'(go), int'(e[8]));
    endtask

    task automatic check_all(input logic [4:0] x, input logic [4:0] xp, input bit have_prev);
        chk_pair("R7", "sym", int'(a_d), a_o, model(1, 1, 1, 3, x));
        chk_pair("R6", "asym", int'(b_d), b_o, model(1, 1, 0, 3, x));
        chk_pair("R4", "swrap", int'(c_d), c_o, model(1, 0, 0, 3, x));
        chk_pair("R5", "uclip", int'(d_d), d_o, model(0, 1, 0, 3, x));
        chk_pair("R4", "uwrap", int'(e_d), e_o, model(0, 0, 0, 3, x));
        chk_pair("R3", "swide", int'(f_d), f_o, model(1, 1, 1, 7, x));
        chk_pair("R3", "uwide", int'(g_d), g_o, model(0, 1, 0, 7, x));
        if (have_prev)
            chk_pair("R1", "two-stage", int'(h_d), h_o, model(1, 1, 1, 3, xp));
    endtask

    task automatic step(input logic [4:0] x, inout logic [4:0] prev, inout bit have_prev);
        din = x;
        @(posedge clk);
        @(negedge clk);
        check_all(x, prev, have_prev);
        prev = x;
        have_prev = 1'b1;
    endtask

    initial begin
        logic [4:0] prev;
        bit have_prev;
        prev = '0;
        have_prev = 1'b0;
        void'($urandom(32'd1234));
        din = 5'd19;
        repeat (3) @(negedge clk);
        // R2: all stages cleared while reset is held, whatever the input
        chk("R2", "reset sym data", int'(a_d), 0);
        chk("R2", "reset sym ovf", int'(a_o), 0);
        chk("R2", "reset uclip data", int'(d_d), 0);
        chk("R2", "reset wide data", int'(f_d), 0);
        chk("R2", "reset two-stage data", int'(h_d), 0);
        chk("R2", "reset two-stage ovf", int'(h_o), 0);
        rst_n = 1'b1;
        // R1: one posedge after reset, the two-stage unit still shows the cleared value
        din = 5'd15;
        @(posedge clk);
        @(negedge clk);
        chk("R1", "two-stage first cycle", int'(h_d), 0);
        chk("R1", "default one-cycle", int'(a_d), int'(model(1, 1, 1, 3, 5'd15) & 9'hFF));
        prev = 5'd15;
        have_prev = 1'b1;
        // Directed corners: R7 exact minimum input -4 (5'b11100), range edges
        step(5'b11100, prev, have_prev);
        step(5'b00011, prev, have_prev);
        step(5'b00100, prev, have_prev);
        step(5'b11011, prev, have_prev);
        step(5'b10000, prev, have_prev);
        step(5'b01111, prev, have_prev);
        step(5'b00111, prev, have_prev);
        step(5'b01000, prev, have_prev);
        for (int i = 0; i < 32; i++) step(5'(i), prev, have_prev);
        for (int i = 0; i < 300; i++) step(5'($urandom % 32), prev, have_prev);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule